// File: doc/BRIEF.md
# SD Bus Command Framer and Reply Checker

This block issues a single command on the command line of an SD card bus and, if asked, receives and checks the card's reply. The caller supplies a 6-bit command index, a 32-bit argument and a reply kind, then pulses a start strobe. The block then does the following:

- It builds a 48-bit frame that carries a computed CRC7.
- It drives the frame out MSB first, using an SD clock derived from the system clock by an enable-driven divider.
- It releases the line and waits for the card's start bit.
- It captures a 48-bit or 136-bit reply, checks it under the rules for that reply kind, and returns the payload.

A one-cycle done pulse ends every command. The ok, CRC error, index mismatch and timeout flags are held until the next accepted start. Data lines, the card bring-up sequence and command ordering belong to the surrounding logic.

Top module: `sd_cmd_engine`

## Requirements
- R1: The command line carries 48 bits, MSB first: start bit 0, direction bit 1, index[5:0], argument[31:0] most significant byte first, CRC7[6:0], end bit 1. A bit changes only on a falling SD clock edge, so it is stable at the rising edge where the card samples it.
- R2: The command CRC7 uses polynomial x^7+x^3+1 and a register cleared to zero. It is computed over the first 40 frame bits. For index 0 with argument 0 the frame is 0x400000000095.
- R3: In the cycle after an accepted start, cmd_oe_o and cmd_o are both 1. The line stays high for one full SD clock period, with one rising edge, before the start bit. cmd_oe_o drops after the end bit.
- R4: rsp_kind_i selects the reply handling: 0 = no reply, 1 = 48-bit checked, 2 = 48-bit unchecked, 3 = 136-bit. With kind 0 the block finishes with ok_o set right after the end bit and samples nothing.
- R5: Reply capture begins with the first 0 sampled on a rising SD clock edge after the line is released. That 0 becomes reply bit 47 (or bit 135), and exactly 48 (or 136) bits are taken.
- R6: For kind 1, the CRC7 is recomputed over reply bits [47:8] and compared with bits [7:1]. A mismatch sets crc_err_o.
- R7: For kind 1, reply bits [47:40] must equal {2'b00, index}, or else idx_err_o is set. Index 41 is exempt from this check.
- R8: For kinds 1 and 2, rsp_arg_o takes reply bits [39:8]. ok_o is set when no error flag is set.
- R9: Kind 2 performs neither the CRC check nor the index check.
- R10: For kind 3, reply bits [135:128] must be 0x3F, or else idx_err_o is set. The CRC7 covers bits [127:8] only and is compared with bits [7:1]. rsp_long_o takes bits [127:0].
- R11: If the reply is not complete within TIMEOUT_CYC system cycles of releasing the line, the block sets timeout_o, pulses done_o and returns to idle. sd_clk_o then parks low.
- R12: start_i is ignored while busy_o is 1. done_o is a one-cycle pulse. The status flags and payload outputs hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| rsp_kind_i | input | 2 | Reply kind (0 none, 1 short checked, 2 short unchecked, 3 long) |
| cmd_i | input | 1 | Command line as seen from the card side |
| sd_clk_o | output | 1 | SD bus clock |
| cmd_o | output | 1 | Command line drive value |
| cmd_oe_o | output | 1 | Command line output enable |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last command completed without error |
| crc_err_o | output | 1 | Reply CRC mismatch |
| idx_err_o | output | 1 | Reply index mismatch |
| timeout_o | output | 1 | Reply did not complete in time |
| rsp_arg_o | output | 32 | Payload of a 48-bit reply |
| rsp_long_o | output | 128 | Bits [127:0] of a 136-bit reply |

## Verification
The hardest states to reach from the ports are the mixed outcomes. Examples are a reply that carries a valid CRC but the wrong index, a CRC-bad reply under the unchecked kind, and the index-41 exemption. Each of these needs a card that answers with a frame the bench has deliberately built to be wrong in exactly one field. The bench therefore contains a behavioural card. It decodes the transmitted frame on rising SD edges. After a gap it answers on falling edges with a reply assembled from a vector table, with the index byte, payload and a CRC-corrupt flag chosen per vector. A silent vector drives the timeout path. A second start strobe issued in the middle of a frame shows that a request made while busy leaves the frame on the line unchanged.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  typedef enum logic [1:0] {
    RSP_NONE        = 2'd0,
    RSP_SHORT       = 2'd1,
    RSP_SHORT_NOCRC = 2'd2,
    RSP_LONG        = 2'd3
  } rsp_kind_e;

  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam logic [6:0] CRC7_POLY    = 7'h09;
  localparam logic [5:0] IDX_NO_ECHO  = 6'd41;
  localparam logic [7:0] LONG_HDR     = 8'h3F;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_of40(input logic [39:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/sd_clk_gen.sv
module sd_clk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sd_clk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          clk_q;
  logic          wrap;

  assign wrap     = (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o   = en_i & wrap & ~clk_q;
  assign fall_o   = en_i & wrap & clk_q;
  assign sd_clk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assert_clk_parked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sd_clk_o);
  assert_rise_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> sd_clk_o);
endmodule

// File: rtl/sd_crc7_ser.sv
module sd_crc7_ser (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  import sd_cmd_pkg::*;

  logic [6:0] crc_q;
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc7_step(crc_q, bit_i);
  end
endmodule

// File: rtl/sd_rsp_eval.sv
module sd_rsp_eval (
  input  logic [1:0]   kind_i,
  input  logic [5:0]   idx_i,
  input  logic [135:0] frame_i,
  input  logic [6:0]   crc_calc_i,
  output logic         crc_bad_o,
  output logic         idx_bad_o
);
  import sd_cmd_pkg::*;

  always_comb begin
    crc_bad_o = 1'b0;
    idx_bad_o = 1'b0;
    unique case (rsp_kind_e'(kind_i))
      RSP_SHORT: begin
        crc_bad_o = (frame_i[7:1] != crc_calc_i);
        idx_bad_o = (idx_i != IDX_NO_ECHO) && (frame_i[47:40] != {2'b00, idx_i});
      end
      RSP_LONG: begin
        crc_bad_o = (frame_i[7:1] != crc_calc_i);
        idx_bad_o = (frame_i[135:128] != LONG_HDR);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int TIMEOUT_CYC = 250000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [5:0]   cmd_idx_i,
  input  logic [31:0]  cmd_arg_i,
  input  logic [1:0]   rsp_kind_i,
  input  logic         cmd_i,
  output logic         sd_clk_o,
  output logic         cmd_o,
  output logic         cmd_oe_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         ok_o,
  output logic         crc_err_o,
  output logic         idx_err_o,
  output logic         timeout_o,
  output logic [31:0]  rsp_arg_o,
  output logic [127:0] rsp_long_o
);
  localparam int TXC_W = $clog2(FRAME_BITS);
  localparam int RXC_W = $clog2(LONG_BITS + 1);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_TX, ST_WAIT, ST_RX, ST_EVAL} state_e;

  state_e              state_q;
  rsp_kind_e           kind_q;
  logic [5:0]          idx_q;
  logic [FRAME_BITS-1:0] tx_sr;
  logic [TXC_W-1:0]    tx_cnt;
  logic [LONG_BITS-1:0] rx_sr;
  logic [RXC_W-1:0]    rx_cnt;
  logic [TMO_W-1:0]    tmo_cnt;
  logic                done_q, ok_q, crc_q, idx_q_err, tmo_q;
  logic [31:0]         arg_out_q;
  logic [127:0]        long_out_q;

  logic       sd_rise, sd_fall;
  logic       crc_clr, crc_en, sampling;
  logic [RXC_W-1:0] bit_k, rx_len;
  logic [6:0] crc_calc;
  logic       crc_bad, idx_bad, tmo_hit;
  logic [39:0] head40;

  assign busy_o     = (state_q != ST_IDLE);
  assign cmd_oe_o   = (state_q == ST_PRE) || (state_q == ST_TX);
  assign cmd_o      = (state_q == ST_TX) ? tx_sr[FRAME_BITS-1] : 1'b1;
  assign done_o     = done_q;
  assign ok_o       = ok_q;
  assign crc_err_o  = crc_q;
  assign idx_err_o  = idx_q_err;
  assign timeout_o  = tmo_q;
  assign rsp_arg_o  = arg_out_q;
  assign rsp_long_o = long_out_q;

  assign head40  = {2'b01, cmd_idx_i, cmd_arg_i};
  assign rx_len  = (kind_q == RSP_LONG) ? RXC_W'(LONG_BITS) : RXC_W'(FRAME_BITS);
  assign tmo_hit = (tmo_cnt == TMO_W'(TIMEOUT_CYC - 1));

  // reply bit k counted from the start bit
  assign sampling = sd_rise && (((state_q == ST_WAIT) && !cmd_i) || (state_q == ST_RX));
  assign bit_k    = (state_q == ST_WAIT) ? '0 : rx_cnt;
  assign crc_clr  = (state_q == ST_IDLE) && start_i;
  assign crc_en   = sampling && ((kind_q == RSP_LONG)
                    ? (bit_k >= RXC_W'(8) && bit_k < RXC_W'(128))
                    : (bit_k < RXC_W'(40)));

  sd_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (busy_o),
    .sd_clk_o(sd_clk_o),
    .rise_o  (sd_rise),
    .fall_o  (sd_fall)
  );

  sd_crc7_ser u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .bit_i (cmd_i),
    .crc_o (crc_calc)
  );

  sd_rsp_eval u_eval (
    .kind_i    (kind_q),
    .idx_i     (idx_q),
    .frame_i   (rx_sr),
    .crc_calc_i(crc_calc),
    .crc_bad_o (crc_bad),
    .idx_bad_o (idx_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      kind_q     <= RSP_NONE;
      idx_q      <= '0;
      tx_sr      <= '0;
      tx_cnt     <= '0;
      rx_sr      <= '0;
      rx_cnt     <= '0;
      tmo_cnt    <= '0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
      crc_q      <= 1'b0;
      idx_q_err  <= 1'b0;
      tmo_q      <= 1'b0;
      arg_out_q  <= '0;
      long_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q     <= cmd_idx_i;
          kind_q    <= rsp_kind_e'(rsp_kind_i);
          tx_sr     <= {head40, crc7_of40(head40), 1'b1};
          rx_sr     <= '0;
          ok_q      <= 1'b0;
          crc_q     <= 1'b0;
          idx_q_err <= 1'b0;
          tmo_q     <= 1'b0;
          state_q   <= ST_PRE;
        end
        ST_PRE: if (sd_fall) begin
          tx_cnt  <= '0;
          state_q <= ST_TX;
        end
        ST_TX: if (sd_fall) begin
          if (tx_cnt == TXC_W'(FRAME_BITS - 1)) begin
            tmo_cnt <= '0;
            if (kind_q == RSP_NONE) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              ok_q    <= 1'b1;
            end else begin
              state_q <= ST_WAIT;
            end
          end else begin
            tx_sr  <= {tx_sr[FRAME_BITS-2:0], 1'b1};
            tx_cnt <= tx_cnt + TXC_W'(1);
          end
        end
        ST_WAIT, ST_RX: begin
          tmo_cnt <= tmo_cnt + TMO_W'(1);
          if (tmo_hit) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
          end else if (sampling) begin
            rx_sr <= {rx_sr[LONG_BITS-2:0], cmd_i};
            if (state_q == ST_WAIT) begin
              rx_cnt  <= RXC_W'(1);
              state_q <= ST_RX;
            end else if (rx_cnt == rx_len - RXC_W'(1)) begin
              state_q <= ST_EVAL;
            end else begin
              rx_cnt <= rx_cnt + RXC_W'(1);
            end
          end
        end
        ST_EVAL: begin
          state_q   <= ST_IDLE;
          done_q    <= 1'b1;
          crc_q     <= crc_bad;
          idx_q_err <= idx_bad;
          ok_q      <= !crc_bad && !idx_bad;
          if (kind_q == RSP_LONG) long_out_q <= rx_sr[127:0];
          else                    arg_out_q  <= rx_sr[39:8];
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_cmd_on_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> $fell(sd_clk_o));
  assert_end_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_oe_o) |-> $past(cmd_o));
  assert_pre_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (cmd_oe_o && cmd_o));
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_no_drive_in_reply_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX) |-> !cmd_oe_o);
endmodule

// File: tb/sd_cmd_engine_test.sv
module sd_cmd_engine_test;
  localparam int HALF = 2;
  localparam int TMO  = 1500;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [1:0]  kind;
    logic [7:0]  ridx;
    logic [31:0] rpay;
    logic        bad_crc;
    logic        silent;
    logic [3:0]  expf;   // {ok, crc, idx, tmo}
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  32'h0000_0000, 2'd0, 8'h00, 32'h0,          1'b0, 1'b0, 4'b1000}, // R4 R2
    '{6'd17, 32'h1234_ABCD, 2'd1, 8'h11, 32'h0000_0900,  1'b0, 1'b0, 4'b1000}, // R6 R8
    '{6'd17, 32'h0000_0200, 2'd1, 8'h11, 32'hDEAD_BEEF,  1'b1, 1'b0, 4'b0100}, // R6
    '{6'd13, 32'hFFFF_0000, 2'd1, 8'h0E, 32'h0000_0700,  1'b0, 1'b0, 4'b0010}, // R7
    '{6'd41, 32'h40FF_8000, 2'd1, 8'h3F, 32'h80FF_8000,  1'b0, 1'b0, 4'b1000}, // R7 exempt
    '{6'd41, 32'h5000_0000, 2'd2, 8'h3F, 32'hC0FF_8000,  1'b1, 1'b0, 4'b1000}, // R9
    '{6'd2,  32'h0000_0000, 2'd3, 8'h3F, 32'h0123_4567,  1'b0, 1'b0, 4'b1000}, // R10
    '{6'd2,  32'h0000_0000, 2'd3, 8'h3F, 32'h89AB_CDEF,  1'b1, 1'b0, 4'b0100}, // R10
    '{6'd9,  32'h0001_0000, 2'd3, 8'h3E, 32'h5555_AAAA,  1'b0, 1'b0, 4'b0010}, // R10
    '{6'd55, 32'h0000_0000, 2'd1, 8'h37, 32'h0,          1'b0, 1'b1, 4'b0001}  // R11
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, cmd_i = 1'b1;
  logic [5:0] cmd_idx_i = '0;
  logic [31:0] cmd_arg_i = '0;
  logic [1:0] rsp_kind_i = '0;
  logic sd_clk_o, cmd_o, cmd_oe_o, busy_o, done_o, ok_o, crc_err_o, idx_err_o, timeout_o;
  logic [31:0] rsp_arg_o;
  logic [127:0] rsp_long_o;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  logic [135:0] card_bits;
  int card_len = 0, card_gap = 2, frames_seen = 0;
  logic [47:0] seen_frame;
  logic seen_pre;

  always #4 clk_i = ~clk_i;

  sd_cmd_engine #(.HALF_DIV(HALF), .TIMEOUT_CYC(TMO)) uut (.*);

  function automatic logic [6:0] bcrc(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, bcrc({96'h0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] mk_reply(input vec_t v);
    logic [119:0] body;
    logic [39:0] h;
    logic [6:0] c;
    if (v.kind == 2'd3) begin
      body = {v.rpay, ~v.rpay, v.rpay, v.rpay[23:0]};
      c = bcrc({16'h0, body}, 120) ^ {6'b0, v.bad_crc};
      return {v.ridx, body, c, 1'b1};
    end
    h = {v.ridx, v.rpay};
    c = bcrc({96'h0, h}, 40) ^ {6'b0, v.bad_crc};
    return {88'h0, h, c, 1'b1};
  endfunction

  task automatic check(input bit cond, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural card
  initial begin
    forever begin
      int got;
      bit first;
      logic [47:0] cap;
      @(posedge cmd_oe_o);
      got = 0; first = 1; cap = '0;
      while (got < 48) begin
        @(posedge sd_clk_o);
        if (first) seen_pre = cmd_o;
        first = 0;
        if (got > 0 || cmd_o == 1'b0) begin
          cap = {cap[46:0], cmd_o};
          got++;
        end
      end
      seen_frame = cap;
      frames_seen++;
      if (card_len > 0) begin
        repeat (card_gap) @(negedge sd_clk_o);
        for (int k = card_len - 1; k >= 0; k--) begin
          @(negedge sd_clk_o);
          cmd_i = card_bits[k];
        end
        @(posedge sd_clk_o);
        #2 cmd_i = 1'b1;
      end
    end
  end

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind);
    @(negedge clk_i);
    cmd_idx_i = idx; cmd_arg_i = arg; rsp_kind_i = kind; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk_i);
      n++;
    end
    check(done_o, tag, {127'b0, done_o}, 128'd1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog R11 actual=%0d expected=<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state
    check(!busy_o && !done_o && !cmd_oe_o && cmd_o && !sd_clk_o, "R12 reset idle",
          {busy_o, done_o, cmd_oe_o, cmd_o, sd_clk_o}, 5'b00010);
    check(!ok_o && !crc_err_o && !idx_err_o && !timeout_o, "R12 reset flags",
          {ok_o, crc_err_o, idx_err_o, timeout_o}, 4'b0000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R3 pre-drive high
    card_len = 0;
    issue(6'd0, 32'h0, 2'd0);
    check(cmd_oe_o && cmd_o && busy_o, "R3 line high after start", {cmd_oe_o, cmd_o, busy_o}, 3'b111);
    wait_done("R4 done");
    check(seen_pre == 1'b1, "R3 first rising edge sees 1", seen_pre, 1'b1);
    check(seen_frame == 48'h400000000095, "R2 CMD0 frame", seen_frame, 48'h400000000095);
    check(!cmd_oe_o, "R3 release after end bit", cmd_oe_o, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [135:0] rb = mk_reply(v);
      card_bits = rb;
      card_len = (v.silent || v.kind == 2'd0) ? 0 : ((v.kind == 2'd3) ? 136 : 48);
      issue(v.idx, v.arg, v.kind);
      wait_done($sformatf("R5 vec%0d done", i));
      check(seen_frame == mk_cmd(v.idx, v.arg), $sformatf("R1 vec%0d frame", i),
            seen_frame, mk_cmd(v.idx, v.arg));
      check({ok_o, crc_err_o, idx_err_o, timeout_o} == v.expf,
            $sformatf("R6 R7 R9 R10 R11 vec%0d flags", i),
            {ok_o, crc_err_o, idx_err_o, timeout_o}, v.expf);
      if (v.expf[3] && (v.kind == 2'd1 || v.kind == 2'd2))
        check(rsp_arg_o == v.rpay, $sformatf("R8 vec%0d payload", i), rsp_arg_o, v.rpay);
      if (v.expf[3] && v.kind == 2'd3)
        check(rsp_long_o == rb[127:0], $sformatf("R10 vec%0d long payload", i), rsp_long_o, rb[127:0]);
      if (v.silent) begin
        repeat (3) @(negedge clk_i);
        check(!sd_clk_o && !busy_o, "R11 clock parked after timeout", {sd_clk_o, busy_o}, 2'b00);
      end
      repeat (4) @(negedge clk_i);
    end

    // R12: start while busy is ignored
    begin
      vec_t v = VECS[1];
      int f0;
      card_bits = mk_reply(v);
      card_len = 48;
      f0 = frames_seen;
      issue(v.idx, v.arg, v.kind);
      repeat (30) @(negedge clk_i);
      cmd_idx_i = 6'd5; cmd_arg_i = 32'hFFFF_FFFF; rsp_kind_i = 2'd0; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      wait_done("R12 busy done");
      check(seen_frame == mk_cmd(v.idx, v.arg), "R12 frame unchanged by busy start",
            seen_frame, mk_cmd(v.idx, v.arg));
      check(frames_seen == f0 + 1, "R12 single frame", frames_seen, f0 + 1);
      check(ok_o && rsp_arg_o == v.rpay, "R12 busy-start result", rsp_arg_o, v.rpay);
      @(negedge clk_i);
      check(!done_o, "R12 done one cycle", done_o, 1'b0);
      repeat (20) @(negedge clk_i);
      check(ok_o && !busy_o && rsp_arg_o == v.rpay, "R12 status held", {ok_o, busy_o}, 2'b10);
    end

    finish_run();
  end
endmodule